// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock from one divisor to another as an ordered series of writes to two registers that sit outside it. The first is a mode register that holds a 3-bit divider code. The second is a memory-control register that holds a self-refresh enable bit and a 7-bit refresh count. A requester names a target divisor by index. The sequencer reads back the current divider code and works out a plan. Some direct jumps are not allowed, so it splits them through divide-by-2. It then carries out each step in the order that step requires.

Every write to the divider is followed by a wait for PLL lock. Every memory-control write is followed by a read-back. The refresh count for each divisor is computed at elaboration from the base clock frequency. When a slowing-down count update finds self-refresh disabled, the block waits until both the old and new refresh counters have drained before it goes on. Memory-control writes are read-modify-write, so bits outside the two fields keep their values. The requester sees a one-cycle acknowledge when the work is done, a busy level while it runs, and an error flag for requests it cannot serve.

Top module: `clkdiv_seq`

## Requirements
- R1: Request index i selects divisor 1, 2, 4, 6 or 8 for i = 0..4. The divider code written is 000, 001, 011, 010 and 100 respectively, and the current divisor is decoded from the read-back code by the same table.
- R2: A request index above 4, or a read-back divider code of 101, 110 or 111, sets `err` and pulses `ack` in the same cycle with no register write. `err` stays set until the next accepted request.
- R3: A request for the divisor already in effect pulses `ack` without any register write.
- R4: A move from divisor 1 to 4, 6 or 8, or from 4, 6 or 8 to divisor 1, runs as two steps: first to divisor 2, then to the target.
- R5: The step from 2 to 1 writes, in order: self-refresh enable cleared, divider code, refresh count for the new divisor. There is no drain wait.
- R6: The step from 1 to 2 writes, in order: refresh count as a slowing-down update, divider code, self-refresh enable set.
- R7: Any other step to a larger divisor writes the refresh count and then the divider code, with no drain wait.
- R8: Any other step to a smaller divisor writes the divider code and then the refresh count as a slowing-down update.
- R9: The refresh count for divisor d is floor(BASE_KHZ × 78 / (640000 × d)), saturated at 127. It is written to bits 14:8 of the memory-control word, and self-refresh enable is bit 16. Every other bit of that word is preserved.
- R10: After a divider-code write, no register write follows for at least LOCK_CYC cycles.
- R11: After a slowing-down count update whose read-back shows self-refresh disabled, the next write comes no earlier than 64 × (old count + new count) × old divisor cycles later.
- R12: `busy` is high from the cycle after a request is accepted until the sequence completes, and `ack` is a single-cycle pulse while `busy` is low. A `req` raised while busy is ignored, and only the planned writes appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled while idle |
| req_idx | input | 3 | Target divisor index |
| ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Last request could not be served |
| mode_wr | output | 1 | Divider-code write strobe |
| mode_wdata | output | 3 | Divider code to write |
| mode_rdata | input | 3 | Current divider code read back |
| mem_wr | output | 1 | Memory-control write strobe |
| mem_wdata | output | 17 | Memory-control word to write |
| mem_rdata | input | 17 | Memory-control word read back |

## Verification
The bench builds the block with BASE_KHZ = 100000, LOCK_CYC = 16 and DRAIN_MARGIN = 4. With these values the refresh counts are 12, 6, 3, 2 and 1. The drain windows are then a few hundred to about twelve hundred cycles, so the bench can afford to time every slowing-down wait exactly. It also covers both split directions, the 1↔2 self-refresh ordering with self-refresh both off and on, a forced illegal read-back code, and a request injected mid-sequence. The low byte of the memory-control word starts non-zero so the bench can see that those bits are preserved.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int IDX_W    = 3;
    localparam int CODE_W   = 3;
    localparam int NUM_DIV  = 5;
    localparam int MEM_W    = 17;
    localparam int SR_BIT   = 16;
    localparam int RC_LSB   = 8;
    localparam int RC_W     = 7;
    localparam int STEP_OPS = 3;
    localparam int PROG_OPS = 2 * STEP_OPS;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_SR_CLR   = 3'd1,
        OP_SR_SET   = 3'd2,
        OP_DIV      = 3'd3,
        OP_REF_FAST = 3'd4,
        OP_REF_SLOW = 3'd5
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [IDX_W-1:0] nidx;   // divisor index after the step
        logic [IDX_W-1:0] oidx;   // divisor index before the step
    } op_t;

    typedef op_t [STEP_OPS-1:0] step_t;
    typedef op_t [PROG_OPS-1:0] prog_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RDBK = 2'd2,
        ST_WAIT = 2'd3
    } state_e;

    function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    return 3'b000;
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            3'd4:    return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    // returns {valid, index}
    function automatic logic [IDX_W:0] code_to_idx(input logic [CODE_W-1:0] c);
        case (c)
            3'b000:  return {1'b1, 3'd0};
            3'b001:  return {1'b1, 3'd1};
            3'b011:  return {1'b1, 3'd2};
            3'b010:  return {1'b1, 3'd3};
            3'b100:  return {1'b1, 3'd4};
            default: return {1'b0, 3'd0};
        endcase
    endfunction

    function automatic int unsigned idx_to_div(input logic [IDX_W-1:0] i);
        case (i)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned refresh_count(input int unsigned base_khz,
                                                  input int unsigned div);
        longint unsigned v;
        v = (longint'(base_khz) * 78) / (longint'(640000) * longint'(div));
        if (v > 127) v = 127;
        return int'(v);
    endfunction

endpackage

// File: rtl/clkdiv_plan.sv
module clkdiv_plan
    import clkdiv_pkg::*;
(
    input  logic [IDX_W-1:0] from_idx,
    input  logic [IDX_W-1:0] to_idx,
    output prog_t            prog
);

    function automatic step_t mk_step(input logic [IDX_W-1:0] a,
                                      input logic [IDX_W-1:0] b);
        step_t s;
        s = '0;
        if (a == 3'd1 && b == 3'd0) begin
            s[0] = '{kind: OP_SR_CLR,   nidx: b, oidx: a};
            s[1] = '{kind: OP_DIV,      nidx: b, oidx: a};
            s[2] = '{kind: OP_REF_FAST, nidx: b, oidx: a};
        end else if (a == 3'd0 && b == 3'd1) begin
            s[0] = '{kind: OP_REF_SLOW, nidx: b, oidx: a};
            s[1] = '{kind: OP_DIV,      nidx: b, oidx: a};
            s[2] = '{kind: OP_SR_SET,   nidx: b, oidx: a};
        end else if (b > a) begin
            s[0] = '{kind: OP_REF_FAST, nidx: b, oidx: a};
            s[1] = '{kind: OP_DIV,      nidx: b, oidx: a};
        end else begin
            s[0] = '{kind: OP_DIV,      nidx: b, oidx: a};
            s[1] = '{kind: OP_REF_SLOW, nidx: b, oidx: a};
        end
        return s;
    endfunction

    logic split;

    always_comb begin
        split = (from_idx == 3'd0 && to_idx >= 3'd2) ||
                (from_idx >= 3'd2 && to_idx == 3'd0);
        if (split)
            prog = {mk_step(3'd1, to_idx), mk_step(from_idx, 3'd1)};
        else
            prog = {step_t'('0), mk_step(from_idx, to_idx)};
    end

endmodule

// File: rtl/clkdiv_refcnt.sv
module clkdiv_refcnt
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_KHZ = 400000
) (
    input  logic [IDX_W-1:0] idx,
    output logic [RC_W-1:0]  cnt
);

    logic [RC_W-1:0] cnt_tab [NUM_DIV];

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_tab
        localparam int unsigned CNT = refresh_count(BASE_KHZ, idx_to_div(IDX_W'(g)));
        assign cnt_tab[g] = RC_W'(CNT);
    end

    always_comb begin
        cnt = '0;
        for (int k = 0; k < NUM_DIV; k++)
            if (idx == IDX_W'(k)) cnt = cnt_tab[k];
    end

endmodule

// File: rtl/clkdiv_drain.sv
module clkdiv_drain
    import clkdiv_pkg::*;
#(
    parameter int unsigned MARGIN = 4,
    parameter int          W      = 20
) (
    input  logic [RC_W-1:0]  old_cnt,
    input  logic [RC_W-1:0]  new_cnt,
    input  logic [IDX_W-1:0] old_idx,
    output logic [W-1:0]     cycles
);

    int unsigned total;

    always_comb begin
        total  = (int'({1'b0, old_cnt}) + int'({1'b0, new_cnt})) * idx_to_div(old_idx) * 64
                 + MARGIN;
        cycles = W'(total);
    end

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int unsigned BASE_KHZ     = 400000,
    parameter int unsigned LOCK_CYC     = 16,
    parameter int unsigned DRAIN_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              ack,
    output logic              busy,
    output logic              err,
    output logic              mode_wr,
    output logic [CODE_W-1:0] mode_wdata,
    input  logic [CODE_W-1:0] mode_rdata,
    output logic              mem_wr,
    output logic [MEM_W-1:0]  mem_wdata,
    input  logic [MEM_W-1:0]  mem_rdata
);

    localparam int unsigned DRAIN_MAX = 64 * 2 * ((1 << RC_W) - 1) * 8 + DRAIN_MARGIN;
    localparam int unsigned WAIT_MAX  = (DRAIN_MAX > LOCK_CYC) ? DRAIN_MAX : LOCK_CYC;
    localparam int          WAIT_W    = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        state_e            st;
        prog_t             prog;
        op_t               cur;
        logic [RC_W-1:0]   old_cnt;
        logic [RC_W-1:0]   new_cnt;
        logic [WAIT_W-1:0] wcnt;
        logic              ack;
        logic              err;
    } regs_t;

    regs_t             r_q, r_d;
    prog_t             plan_prog;
    op_t               head;
    logic [IDX_W:0]    cur_dec;
    logic              cur_ok;
    logic [IDX_W-1:0]  cur_idx;
    logic [RC_W-1:0]   ref_cnt;
    logic [WAIT_W-1:0] drain_cyc;

    assign head    = r_q.prog[0];
    assign cur_dec = code_to_idx(mode_rdata);
    assign cur_ok  = cur_dec[IDX_W];
    assign cur_idx = cur_dec[IDX_W-1:0];

    clkdiv_plan u_plan (
        .from_idx (cur_idx),
        .to_idx   (req_idx),
        .prog     (plan_prog)
    );

    clkdiv_refcnt #(.BASE_KHZ(BASE_KHZ)) u_ref (
        .idx (head.nidx),
        .cnt (ref_cnt)
    );

    clkdiv_drain #(.MARGIN(DRAIN_MARGIN), .W(WAIT_W)) u_drain (
        .old_cnt (r_q.old_cnt),
        .new_cnt (r_q.new_cnt),
        .old_idx (r_q.cur.oidx),
        .cycles  (drain_cyc)
    );

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        mode_wr    = 1'b0;
        mode_wdata = '0;
        mem_wr     = 1'b0;
        mem_wdata  = mem_rdata;
        case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.err = 1'b0;
                    if (req_idx >= IDX_W'(NUM_DIV) || !cur_ok) begin
                        r_d.err = 1'b1;
                        r_d.ack = 1'b1;
                    end else if (cur_idx == req_idx) begin
                        r_d.ack = 1'b1;
                    end else begin
                        r_d.prog = plan_prog;
                        r_d.st   = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                if (r_q.prog == '0) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.prog = prog_t'(r_q.prog >> $bits(op_t));
                    r_d.cur  = head;
                    case (head.kind)
                        OP_DIV: begin
                            mode_wr    = 1'b1;
                            mode_wdata = idx_to_code(head.nidx);
                            r_d.wcnt   = WAIT_W'(LOCK_CYC - 1);
                            r_d.st     = ST_WAIT;
                        end
                        OP_SR_CLR, OP_SR_SET: begin
                            mem_wr            = 1'b1;
                            mem_wdata[SR_BIT] = (head.kind == OP_SR_SET);
                            r_d.st            = ST_RDBK;
                        end
                        OP_REF_FAST, OP_REF_SLOW: begin
                            mem_wr                      = 1'b1;
                            mem_wdata[RC_LSB +: RC_W]   = ref_cnt;
                            r_d.old_cnt                 = mem_rdata[RC_LSB +: RC_W];
                            r_d.new_cnt                 = ref_cnt;
                            r_d.st                      = ST_RDBK;
                        end
                        default: r_d.st = ST_EXEC;
                    endcase
                end
            end
            ST_RDBK: begin
                if (r_q.cur.kind == OP_REF_SLOW && !mem_rdata[SR_BIT] && drain_cyc != '0) begin
                    r_d.wcnt = drain_cyc - 1'b1;
                    r_d.st   = ST_WAIT;
                end else begin
                    r_d.st = ST_EXEC;
                end
            end
            ST_WAIT: begin
                if (r_q.wcnt == '0) r_d.st = ST_EXEC;
                else                r_d.wcnt = r_q.wcnt - 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ack  = r_q.ack;
    assign err  = r_q.err;
    assign busy = (r_q.st != ST_IDLE);

endmodule

// File: rtl/clkdiv_seq_chk.sv
module clkdiv_seq_chk
    import clkdiv_pkg::*;
#(
    parameter int unsigned LOCK_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              busy,
    input logic              err,
    input logic              mode_wr,
    input logic [CODE_W-1:0] mode_wdata,
    input logic              mem_wr
);

    localparam int SW = $clog2(LOCK_CYC + 1);

    logic [SW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     since_q <= SW'(LOCK_CYC);
        else if (mode_wr)               since_q <= '0;
        else if (since_q < SW'(LOCK_CYC)) since_q <= since_q + 1'b1;
    end

    // R10
    lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr || mem_wr) |-> (since_q >= SW'(LOCK_CYC)));

    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> (mode_wdata inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100}));

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R12
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !busy);

    // R12
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_wr && mem_wr));

    // R2
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ack);

endmodule

bind clkdiv_seq clkdiv_seq_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .busy       (busy),
    .err        (err),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mem_wr     (mem_wr)
);

// File: tb/clkdiv_seq_test.sv
module clkdiv_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_KHZ   = 100000;
    localparam int LOCK       = 16;
    localparam int MARGIN     = 4;

    localparam int K_SRCLR = 0, K_SRSET = 1, K_DIV = 2, K_REFF = 3, K_REFS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  req_idx = '0;
    logic        ack, busy, err;
    logic        mode_wr, mem_wr;
    logic [2:0]  mode_wdata, mode_rdata;
    logic [16:0] mem_wdata, mem_rdata;

    logic [2:0]  mode_q = 3'b000;
    logic [16:0] mem_q  = 17'h000A5;
    logic        bad_code = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;
    longint next_ok = 0;
    string  gap_tag = "R10";
    int     cur = 0;

    int    q_kind[$], q_idx[$], q_old[$];
    string q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mode_rdata = bad_code ? 3'b111 : mode_q;
    assign mem_rdata  = mem_q;

    always @(posedge clk) begin
        if (mode_wr) mode_q <= mode_wdata;
        if (mem_wr)  mem_q  <= mem_wdata;
    end

    clkdiv_seq #(.BASE_KHZ(BASE_KHZ), .LOCK_CYC(LOCK), .DRAIN_MARGIN(MARGIN)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_idx(req_idx),
        .ack(ack), .busy(busy), .err(err),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int bdiv(input int i);
        int d[5] = '{1, 2, 4, 6, 8};
        return d[i];
    endfunction

    function automatic logic [2:0] bcode(input int i);
        logic [2:0] c[5] = '{3'b000, 3'b001, 3'b011, 3'b010, 3'b100};
        return c[i];
    endfunction

    function automatic int bcnt(input int i);
        int v = (BASE_KHZ * 78) / (640000 * bdiv(i));
        return (v > 127) ? 127 : v;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int k, input int i, input int o, input string t);
        q_kind.push_back(k); q_idx.push_back(i); q_old.push_back(o); q_tag.push_back(t);
    endtask

    task automatic plan_step(input int a, input int b, input string pre);
        if (a == 1 && b == 0) begin
            push(K_SRCLR, b, a, {pre, "R5"}); push(K_DIV, b, a, {pre, "R5"});
            push(K_REFF, b, a, {pre, "R5"});
        end else if (a == 0 && b == 1) begin
            push(K_REFS, b, a, {pre, "R6"}); push(K_DIV, b, a, {pre, "R6"});
            push(K_SRSET, b, a, {pre, "R6"});
        end else if (b > a) begin
            push(K_REFF, b, a, {pre, "R7"}); push(K_DIV, b, a, {pre, "R7"});
        end else begin
            push(K_DIV, b, a, {pre, "R8"}); push(K_REFS, b, a, {pre, "R8"});
        end
    endtask

    task automatic plan(input int f, input int t);
        if ((f == 0 && t >= 2) || (f >= 2 && t == 0)) begin
            plan_step(f, 1, "R4 ");
            plan_step(1, t, "R4 ");
        end else begin
            plan_step(f, t, "");
        end
    endtask

    // reference model: compares every write against the expected sequence
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && (mode_wr || mem_wr)) begin
            if (q_kind.size() == 0) begin
                check(1'b0, "R12 unexpected write", {mode_wr, mem_wr}, 0);
            end else begin
                int k, i, o;
                string t;
                logic [16:0] exp_mem;
                k = q_kind.pop_front(); i = q_idx.pop_front();
                o = q_old.pop_front();  t = q_tag.pop_front();
                check(cyc >= next_ok, {gap_tag, " write spacing"}, cyc, next_ok);
                check(mode_wr == (k == K_DIV) && mem_wr == (k != K_DIV),
                      {t, " write order"}, {mode_wr, mem_wr}, k);
                exp_mem = mem_q;
                next_ok = cyc + 1;
                gap_tag = "R11";
                case (k)
                    K_DIV: begin
                        check(mode_wdata == bcode(i), {t, " R1 divider code"}, mode_wdata, bcode(i));
                        next_ok = cyc + LOCK;
                        gap_tag = "R10";
                    end
                    K_SRCLR: exp_mem[16] = 1'b0;
                    K_SRSET: exp_mem[16] = 1'b1;
                    default: begin
                        exp_mem[14:8] = 7'(bcnt(i));
                        if (k == K_REFS && !mem_q[16])
                            next_ok = cyc + 64 * (int'(mem_q[14:8]) + bcnt(i)) * bdiv(o);
                    end
                endcase
                if (k != K_DIV)
                    check(mem_wdata == exp_mem, {t, " R9 memory word"}, mem_wdata, exp_mem);
            end
        end
    end

    task automatic do_req(input int idx, input bit exp_err);
        while (busy) @(negedge clk);
        req = 1'b1;
        req_idx = 3'(idx);
        if (!exp_err && idx != cur) plan(cur, idx);
        @(negedge clk);
        req = 1'b0;
        if (!exp_err && idx != cur) check(busy, "R12 busy after accept", busy, 1);
        while (!ack) @(negedge clk);
        check(err == exp_err, "R2 error flag", err, exp_err);
        check(q_kind.size() == 0, "R12 sequence complete", q_kind.size(), 0);
        if (!exp_err) cur = idx;
        check(mode_q == bcode(cur), "R1 final divider code", mode_q, bcode(cur));
        @(negedge clk);
        check(!ack, "R12 ack single pulse", ack, 0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !ack && !err, "R12 reset state", {busy, ack, err}, 0);
        check(!mode_wr && !mem_wr, "R12 no write after reset", {mode_wr, mem_wr}, 0);

        do_req(1, 0);  // R6 1->2, self-refresh off: drain
        check(mem_q[16] == 1'b1, "R6 self-refresh set", mem_q[16], 1);
        do_req(4, 0);  // R7 2->8
        do_req(0, 0);  // R4 8->1 through 2
        check(mem_q[16] == 1'b0, "R5 self-refresh cleared", mem_q[16], 0);
        do_req(0, 0);  // R3 same divisor
        do_req(3, 0);  // R4 1->6 through 2, long drain
        do_req(2, 0);  // R8 6->4
        do_req(5, 1);  // R2 index out of range
        do_req(2, 0);  // R3 same, clears err
        bad_code = 1'b1;
        do_req(1, 1);  // R2 illegal read-back code
        bad_code = 1'b0;

        // R12 request raised while busy is ignored
        while (busy) @(negedge clk);
        req = 1'b1; req_idx = 3'd4;
        plan(cur, 4);
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        check(busy, "R12 busy mid sequence", busy, 1);
        req = 1'b1; req_idx = 3'd0;
        @(negedge clk);
        req = 1'b0;
        while (!ack) @(negedge clk);
        cur = 4;
        check(q_kind.size() == 0, "R12 injected request ignored", q_kind.size(), 0);
        check(mode_q == bcode(4), "R12 divider after injection", mode_q, bcode(4));
        repeat (30) @(negedge clk);
        check(!busy && q_kind.size() == 0, "R12 no extra sequence", busy, 0);

        do_req(1, 0);  // R8 8->2, self-refresh on: no drain
        do_req(0, 0);  // R5 2->1
        repeat (5) @(negedge clk);
        summary();
    end

endmodule